// File: doc/BRIEF.md
# Cascadable Successive Approximation Register

This block is the digital half of a successive approximation analog-to-digital loop. Its parallel outputs drive an external DAC, and it reads one comparator bit on each rising clock edge. It tests one trial bit at a time, from the most significant bit down to the least. Each trial bit is raised, and on the next edge it is kept or cleared according to the comparator. When the last bit is settled, an end-of-convert flag rises on the falling half of the clock. The bits are also sent out serially, one bit in the period after each one is decided.

Conversions are started by a rising start input (strobed use). They can also run back to back when the end-of-convert flag is fed to the start input (free-run use). A synchronous master clear empties the register. A feed-forward input ends the conversion early, so a shorter register can be built and chips can be cascaded. In that case the flag fires at the stage where feed-forward was seen high, and the lower bits that keep toggling are to be ignored.

Top module: `sar_cascade`

## Requirements
- R1: While rst_ni is low, q_o, eoc_o and sout_o are all 0.
- R2: start_i is sampled on rising edges against its value at the previous edge. A rising edge of start_i begins a conversion. After that edge, q_o holds only its top bit set (0x80 for 8 bits), and eoc_o is low from the following falling edge.
- R3: mr_i high at a rising edge clears q_o and sout_o at that edge, and eoc_o at the next falling edge. After mr_i is released with start_i low, the block stays idle with q_o at 0. With start_i high, a conversion begins at the first edge after release.
- R4: While converting, each rising edge resolves the current trial bit to cmp_i (1 keeps the bit, 0 clears it) and raises the next lower bit. Resolved bits hold, and after WIDTH resolving edges q_o keeps the result until a clear or a new start.
- R5: eoc_o rises at the falling edge that follows the edge resolving bit 0, and stays high until a clear or a new start.
- R6: During the clock period after the edge that resolves bit k, sout_o equals the value bit k took.
- R7: sout_o is 0 in the period after a start edge, and in every period that follows a non-resolving edge.
- R8: A new rising edge of start_i during a conversion restarts it from the top bit. The next WIDTH resolving edges give the result for the current comparator input.
- R9: ff_i high at a resolving edge marks the conversion complete at that edge, and eoc_o rises at the next falling edge. The lower bits are still resolved on later edges, but sout_o stays 0 for them. With ff_i tied to q_o[2], an 8-bit block gives a 6-bit conversion.
- R10: With start_i driven by eoc_o, a conversion begins on the edge after each completion. eoc_o rises once every WIDTH+1 rising edges, and each time it rises q_o holds the fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; control and data sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-convert; a rising transition begins a conversion |
| cmp_i | input | 1 | Comparator result; 1 keeps the current trial bit |
| mr_i | input | 1 | Synchronous master clear |
| ff_i | input | 1 | Feed-forward early completion |
| q_o | output | WIDTH | Trial/result bits to the DAC |
| eoc_o | output | 1 | End-of-convert, updated on falling edge |
| sout_o | output | 1 | Serial result, MSB first |

## Verification
A wrong trial pointer shows at q_o on the very next rising edge. The wrong bit is raised or left unresolved, and the register no longer matches the upper bits of the analog value. A completion flag set at the wrong time shows half a cycle later as an early or missing eoc_o edge. A missed restart or clear leaves a stale result on q_o on the following edge. The comparator is modelled against a stored value that is swept through every code, so any bit resolved out of order ends in a final code that differs from the value.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_BEGIN = 2'd2,
    ACT_STEP  = 2'd3
  } sar_act_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     mr_i,
  input  logic     busy_i,
  input  logic     complete_i,
  output sar_act_e act_o
);
  logic start_q;
  logic start_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  assign start_rise = start_i & ~start_q;

  // level start also fires when neither running nor done: no stuck idle state
  always_comb begin
    if (mr_i)                                              act_o = ACT_CLEAR;
    else if (start_rise || (start_i && !busy_i && !complete_i)) act_o = ACT_BEGIN;
    else if (busy_i)                                       act_o = ACT_STEP;
    else                                                   act_o = ACT_IDLE;
  end

  AST_NO_BEGIN_WITHOUT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> act_o != ACT_BEGIN); // R2
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sar_act_e         act_i,
  input  logic             ff_i,
  output logic [WIDTH-1:0] ptr_o,
  output logic             busy_o,
  output logic             complete_o
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_CLEAR: begin ptr_q <= '0;       done_q <= 1'b0; end
        ACT_BEGIN: begin ptr_q <= TOP_ONLY; done_q <= 1'b0; end
        ACT_STEP: begin
          ptr_q <= ptr_q >> 1;
          if (ptr_q[0] || ff_i) done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ptr_o      = ptr_q;
  assign busy_o     = |ptr_q;
  assign complete_o = done_q;

  AST_PTR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_o)); // R4
  AST_LAST_STEP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_STEP && ptr_o[0]) |=> (!busy_o && complete_o)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_o && act_i == ACT_STEP) |=> complete_o); // R9
endmodule

// File: rtl/sar_bits.sv
module sar_bits
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sar_act_e         act_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             complete_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] q_o,
  output logic             sout_o
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] q_q;
  logic             sout_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic arm;
    if (i == WIDTH - 1) begin : g_top
      assign arm = 1'b0;
    end else begin : g_low
      assign arm = ptr_i[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[i] <= 1'b0;
      else begin
        unique case (act_i)
          ACT_CLEAR: q_q[i] <= 1'b0;
          ACT_BEGIN: q_q[i] <= TOP_ONLY[i];
          ACT_STEP: begin
            if (ptr_i[i])  q_q[i] <= cmp_i;
            else if (arm)  q_q[i] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // serial bit shown for the period after its resolving edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sout_q <= 1'b0;
    else         sout_q <= (act_i == ACT_STEP) && !complete_i && cmp_i;
  end

  assign q_o    = q_q;
  assign sout_o = sout_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_CLEAR |=> q_o == '0); // R3
  AST_BEGIN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_BEGIN |=> q_o == TOP_ONLY); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_IDLE |=> $stable(q_o)); // R4
  AST_SOUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i != ACT_STEP |=> !sout_o); // R7
endmodule

// File: rtl/sar_cascade.sv
module sar_cascade
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             mr_i,
  input  logic             ff_i,
  output logic [WIDTH-1:0] q_o,
  output logic             eoc_o,
  output logic             sout_o
);
  sar_act_e         act;
  logic [WIDTH-1:0] ptr;
  logic             busy;
  logic             complete;
  logic             eoc_q;

  sar_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mr_i       (mr_i),
    .busy_i     (busy),
    .complete_i (complete),
    .act_o      (act)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .ff_i       (ff_i),
    .ptr_o      (ptr),
    .busy_o     (busy),
    .complete_o (complete)
  );

  sar_bits #(.WIDTH(WIDTH)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .ptr_i      (ptr),
    .complete_i (complete),
    .cmp_i      (cmp_i),
    .q_o        (q_o),
    .sout_o     (sout_o)
  );

  // flag settles half a cycle after the register state
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_q <= 1'b0;
    else         eoc_q <= complete;
  end

  assign eoc_o = eoc_q;

  AST_EOC_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o == complete); // R5
  AST_FIRST_PERIOD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_BEGIN |=> !sout_o); // R7
endmodule

// File: tb/sar_cascade_bench.sv
module sar_cascade_bench;
  localparam int  W          = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_drv = 1'b0;
  logic         mr = 1'b0;
  logic         ff_en = 1'b0;
  logic         free_run = 1'b0;
  logic [W-1:0] v = '0;
  logic [W-1:0] q;
  logic         eoc, sout;
  logic         start_w, cmp_w, ff_w;
  int           checks = 0;
  int           errors = 0;

  assign start_w = start_drv | (free_run & eoc);
  assign cmp_w   = (q <= v);
  assign ff_w    = ff_en & q[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_cascade #(.WIDTH(W)) u_sar_cascade (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_w), .cmp_i(cmp_w),
    .mr_i(mr), .ff_i(ff_w), .q_o(q), .eoc_o(eoc), .sout_o(sout)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic fall();
    @(negedge clk); #1;
  endtask

  task automatic conv(input logic [W-1:0] val, input bit ffm);
    int last;
    logic [W-1:0] mask;
    last = ffm ? 2 : 0;
    v = val;
    start_drv = 1'b1;
    step();
    chk("R2 top bit after start", q, 32'h80);
    chk("R7 first period quiet", sout, 0);
    start_drv = 1'b0;
    fall();
    chk("R2 eoc low after start", eoc, 0);
    for (int k = W-1; k >= 0; k--) begin
      step();
      mask = ~((W'(1) << k) - W'(1));
      chk("R4 resolved upper bits", q & mask, val & mask);
      if (k > 0) chk("R4 next trial raised", q[k-1], 1);
      if (ffm && k < 2) chk("R9 serial muted after ff", sout, 0);
      else              chk("R6 serial bit", sout, val[k]);
      if (k == last) begin
        chk("R5 eoc low before falling edge", eoc, 0);
        fall();
        chk(ffm ? "R9 eoc at ff stage" : "R5 eoc rises", eoc, 1);
      end else if (k < last) begin
        chk("R9 eoc held", eoc, 1);
      end
    end
    step();
    chk("R4 result held", q, val);
    chk("R5 eoc stays high", eoc, 1);
    chk("R7 idle serial quiet", sout, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 q in reset", q, 0);
    chk("R1 eoc in reset", eoc, 0);
    chk("R1 sout in reset", sout, 0);
    rst_ni = 1'b1;
    step(); step();
    chk("R3 idle without start", q, 0);

    // strobed sweep over all codes
    for (int i = 0; i < (1 << W); i++) conv(W'(i), 1'b0);

    // feed-forward tied to q[2]: six-bit conversions
    ff_en = 1'b1;
    for (int i = 0; i < (1 << W); i += 5) conv(W'(i), 1'b1);
    ff_en = 1'b0;

    // restart mid-conversion
    v = 8'hA5;
    start_drv = 1'b1; step(); start_drv = 1'b0;
    step(); step(); step();
    start_drv = 1'b1; step();
    chk("R8 restart from top bit", q, 32'h80);
    chk("R8 serial quiet on restart", sout, 0);
    start_drv = 1'b0;
    v = 8'h3C;
    repeat (W) step();
    fall();
    chk("R8 result after restart", q, 32'h3C);
    chk("R8 eoc after restart", eoc, 1);

    // master clear after completion, start low
    mr = 1'b1; step();
    chk("R3 clear empties q", q, 0);
    chk("R3 clear quiets serial", sout, 0);
    mr = 1'b0;
    fall();
    chk("R3 eoc drops after clear", eoc, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 stays idle", q, 0);
      chk("R3 eoc stays low", eoc, 0);
    end

    // master clear mid-conversion with start held high
    v = 8'h77;
    start_drv = 1'b1; step();
    chk("R2 begin on edge", q, 32'h80);
    step();
    mr = 1'b1; step();
    chk("R3 clear mid conversion", q, 0);
    mr = 1'b0; step();
    chk("R3 level start after release", q, 32'h80);
    start_drv = 1'b0;
    repeat (W) step();
    chk("R3 result after level start", q, 32'h77);

    // free-run
    mr = 1'b1; step(); mr = 1'b0;
    v = 8'h12;
    free_run = 1'b1;
    start_drv = 1'b1; step(); start_drv = 1'b0;
    for (int n = 0; n < 4; n++) begin
      cnt = 0;
      do begin
        step(); cnt++;
        fall();
      end while (!eoc && cnt < 50);
      chk("R10 edges per conversion", cnt, (n == 0) ? W : W + 1);
      chk("R10 fresh result", q, v);
      v = v + 8'h3B;
    end
    free_run = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule